// File: doc/BRIEF.md
# Dual-Lane Panel Pixel Formatter

This block sits at the very end of a display pipeline. It takes one RGB pixel per display clock, together with a data-enable strobe and horizontal and vertical sync, and formats the stream for a flat panel. Two lane modes are available. In two-lane mode, pixels are paired. The first pixel of each pair goes to the even port and the second to the odd port, and both ports refresh together once every two clocks. In single-lane mode, every pixel leaves on the odd port and the even port stays quiet.

The block also generates the panel clocks: a full-rate clock and its complement, and a half-rate clock and its complement. The half-rate clock is phased so that it rises exactly when the paired ports refresh. When the panel takes only 6 bits per channel, the 8-bit input is reduced with a 2x2 ordered dither. The dither pattern moves with line parity and flips every frame, so the panel shows more apparent depth than 6 bits. The sync and enable outputs pass through the same number of registers as the data, so they stay aligned with it.

Top module: `pfmt_panel_fmt`

## Requirements
- R1: In two-lane mode (two_phase=1), the active pixels of a line are numbered from 0. Pixel 2k appears on the even port and pixel 2k+1 on the odd port, both updated on the clock edge after the one that samples pixel 2k+1. Both ports then hold until the next pair update.
- R2: Pixel numbering restarts at 0 on every rising edge of de_in, even after a single idle cycle between lines.
- R3: In two-lane mode, when a line has an odd pixel count, its last pixel appears on the even port with the odd port at zero. This happens two clock edges after that pixel is sampled.
- R4: In single-lane mode (two_phase=0), each pixel appears on the odd port on the edge after the one that samples it. The odd port is zero when the matching de_out is low.
- R5: In single-lane mode the even port is held at zero.
- R6: de_out, hs_out and vs_out equal de_in, hs_in and vs_in as sampled two clock edges earlier.
- R7: With depth6=0, the channel values pass through unchanged.
- R8: With depth6=1, a channel value v becomes q=v[7:2], plus one if v[1:0] exceeds the threshold t, saturating at 63. The result is driven as {q,2'b00}, so output bits [1:0] are always low.
- R9: The threshold t is indexed by pixel parity x (pixel number bit 0) and phase p. It is t=0 for p=0,x=0; t=2 for p=0,x=1; t=3 for p=1,x=0; and t=1 for p=1,x=1. The phase p is the line parity XOR the frame parity. Line parity is cleared by a rising vs_in and toggles on each falling de_in. Frame parity toggles on each rising vs_in.
- R10: dclk_full follows clk. dclk_half toggles every cycle, except that in two-lane mode it is forced high on every port update. dclk_full_n and dclk_half_n are the complements.
- R11: While rst_n is low, all data, sync, enable and half-rate clock outputs are zero, and dclk_half_n is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| two_phase | input | 1 | 1 = two-lane output, 0 = single-lane on odd port |
| depth6 | input | 1 | 1 = 6-bit dithered output, 0 = 8-bit |
| de_in | input | 1 | Input data enable |
| hs_in | input | 1 | Input horizontal sync |
| vs_in | input | 1 | Input vertical sync |
| in_r | input | 8 | Input red |
| in_g | input | 8 | Input green |
| in_b | input | 8 | Input blue |
| ev_r | output | 8 | Even-port red |
| ev_g | output | 8 | Even-port green |
| ev_b | output | 8 | Even-port blue |
| od_r | output | 8 | Odd-port red |
| od_g | output | 8 | Odd-port green |
| od_b | output | 8 | Odd-port blue |
| de_out | output | 1 | Delayed data enable |
| hs_out | output | 1 | Delayed horizontal sync |
| vs_out | output | 1 | Delayed vertical sync |
| dclk_full | output | 1 | Full-rate panel clock |
| dclk_full_n | output | 1 | Complement of dclk_full |
| dclk_half | output | 1 | Half-rate panel clock |
| dclk_half_n | output | 1 | Complement of dclk_half |

## Verification
A pixel-parity tracker that slips shows up at the ports as a swapped pair: the even and odd values trade places, visible on the first pair update of the line, two edges after the second pixel. A lost pending flag makes the final pixel of an odd-length line disappear, so the fill word never appears. Wrong line or frame phase shows as dithered values off by one LSB step in 6-bit mode on the first affected pixel. A wrong sync delay is visible within two cycles of any enable or sync transition.

// File: rtl/pfmt_pkg.sv
package pfmt_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PAIR = 2'd1,
    OP_FILL = 2'd2,
    OP_PASS = 2'd3
  } lane_op_e;

  // 2x2 ordered threshold, indexed by line phase and pixel parity
  function automatic logic [1:0] bayer_thr(input logic ph, input logic x);
    case ({ph, x})
      2'b00:   return 2'd0;
      2'b01:   return 2'd2;
      2'b10:   return 2'd3;
      default: return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/pfmt_frame_track.sv
module pfmt_frame_track (
  input  logic clk,
  input  logic rst_n,
  input  logic de_in,
  input  logic vs_in,
  output logic x_odd,
  output logic line_ph
);

  logic de_d_q, vs_d_q, nxt_odd_q, row_q, frm_q;
  logic nxt_odd_d, row_d, frm_d;
  logic de_rise, de_fall, vs_rise;

  always_comb begin
    de_rise   = de_in & ~de_d_q;
    de_fall   = ~de_in & de_d_q;
    vs_rise   = vs_in & ~vs_d_q;
    x_odd     = de_rise ? 1'b0 : nxt_odd_q;
    nxt_odd_d = de_in ? ~x_odd : nxt_odd_q;
    if (vs_rise)      row_d = 1'b0;
    else if (de_fall) row_d = ~row_q;
    else              row_d = row_q;
    frm_d     = vs_rise ? ~frm_q : frm_q;
    line_ph   = row_q ^ frm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_d_q    <= 1'b0;
      vs_d_q    <= 1'b0;
      nxt_odd_q <= 1'b0;
      row_q     <= 1'b0;
      frm_q     <= 1'b0;
    end else begin
      de_d_q    <= de_in;
      vs_d_q    <= vs_in;
      nxt_odd_q <= nxt_odd_d;
      row_q     <= row_d;
      frm_q     <= frm_d;
    end
  end

endmodule

// File: rtl/pfmt_dither.sv
module pfmt_dither
  import pfmt_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int OUT_W = 6
) (
  input  logic [IN_W-1:0] val,
  input  logic            x_odd,
  input  logic            line_ph,
  output logic [IN_W-1:0] res
);

  localparam int DROP = IN_W - OUT_W;

  logic [OUT_W-1:0] msb;
  logic [DROP-1:0]  frac, thr;
  logic             bump;

  always_comb begin
    msb  = val[IN_W-1:DROP];
    frac = val[DROP-1:0];
    thr  = DROP'(bayer_thr(line_ph, x_odd)) << (DROP - 2);
    bump = (frac > thr) && (msb != {OUT_W{1'b1}});
    res  = {msb + OUT_W'(bump), {DROP{1'b0}}};
  end

endmodule

// File: rtl/pfmt_lane_pack.sv
module pfmt_lane_pack
  import pfmt_pkg::*;
#(
  parameter int CH_W = 8,
  parameter int NCH  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      two_phase,
  input  logic [NCH-1:0][CH_W-1:0]  s1_pix,
  input  logic                      s1_de,
  input  logic                      s1_odd,
  input  logic                      s1_hs,
  input  logic                      s1_vs,
  output logic [NCH-1:0][CH_W-1:0]  even_pix,
  output logic [NCH-1:0][CH_W-1:0]  odd_pix,
  output logic                      de_o,
  output logic                      hs_o,
  output logic                      vs_o,
  output logic                      half_o
);

  lane_op_e                 op;
  logic                     hold_en, pend_d, pend_q, half_d, half_q;
  logic [NCH-1:0][CH_W-1:0] hold_q, even_d, even_q, odd_d, odd_q;
  logic                     de_q, hs_q, vs_q;

  always_comb begin
    if (!two_phase)              op = OP_PASS;
    else if (s1_de && s1_odd)    op = OP_PAIR;
    else if (!s1_de && pend_q)   op = OP_FILL;
    else                         op = OP_IDLE;

    hold_en = two_phase & s1_de & ~s1_odd;
    pend_d  = hold_en;

    even_d = even_q;
    odd_d  = odd_q;
    half_d = ~half_q;
    case (op)
      OP_PASS: begin
        even_d = '0;
        odd_d  = s1_pix;
      end
      OP_PAIR: begin
        even_d = hold_q;
        odd_d  = s1_pix;
        half_d = 1'b1;
      end
      OP_FILL: begin
        even_d = hold_q;
        odd_d  = '0;
        half_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      pend_q <= 1'b0;
      even_q <= '0;
      odd_q  <= '0;
      half_q <= 1'b0;
      de_q   <= 1'b0;
      hs_q   <= 1'b0;
      vs_q   <= 1'b0;
    end else begin
      if (hold_en) hold_q <= s1_pix;
      pend_q <= pend_d;
      even_q <= even_d;
      odd_q  <= odd_d;
      half_q <= half_d;
      de_q   <= s1_de;
      hs_q   <= s1_hs;
      vs_q   <= s1_vs;
    end
  end

  assign even_pix = even_q;
  assign odd_pix  = odd_q;
  assign de_o     = de_q;
  assign hs_o     = hs_q;
  assign vs_o     = vs_q;
  assign half_o   = half_q;

endmodule

// File: rtl/pfmt_panel_fmt.sv
module pfmt_panel_fmt #(
  parameter int CH_W  = 8,
  parameter int OUT_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            two_phase,
  input  logic            depth6,
  input  logic            de_in,
  input  logic            hs_in,
  input  logic            vs_in,
  input  logic [CH_W-1:0] in_r,
  input  logic [CH_W-1:0] in_g,
  input  logic [CH_W-1:0] in_b,
  output logic [CH_W-1:0] ev_r,
  output logic [CH_W-1:0] ev_g,
  output logic [CH_W-1:0] ev_b,
  output logic [CH_W-1:0] od_r,
  output logic [CH_W-1:0] od_g,
  output logic [CH_W-1:0] od_b,
  output logic            de_out,
  output logic            hs_out,
  output logic            vs_out,
  output logic            dclk_full,
  output logic            dclk_full_n,
  output logic            dclk_half,
  output logic            dclk_half_n
);

  localparam int NCH = 3;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  logic x_odd, line_ph;

  pfmt_frame_track trk_i (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .de_in   (de_in),
    .vs_in   (vs_in),
    .x_odd   (x_odd),
    .line_ph (line_ph)
  );

  logic [NCH-1:0][CH_W-1:0] raw, dith, s1_pix_d, s1_pix_q;
  logic                     s1_de_q, s1_hs_q, s1_vs_q, s1_odd_q;

  assign raw = {in_b, in_g, in_r};

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      pfmt_dither #(.IN_W(CH_W), .OUT_W(OUT_W)) dith_i (
        .val     (raw[ch]),
        .x_odd   (x_odd),
        .line_ph (line_ph),
        .res     (dith[ch])
      );
    end
  endgenerate

  always_comb begin
    if (!de_in)      s1_pix_d = '0;
    else if (depth6) s1_pix_d = dith;
    else             s1_pix_d = raw;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      s1_pix_q <= '0;
      s1_de_q  <= 1'b0;
      s1_hs_q  <= 1'b0;
      s1_vs_q  <= 1'b0;
      s1_odd_q <= 1'b0;
    end else begin
      s1_pix_q <= s1_pix_d;
      s1_de_q  <= de_in;
      s1_hs_q  <= hs_in;
      s1_vs_q  <= vs_in;
      s1_odd_q <= x_odd;
    end
  end

  logic [NCH-1:0][CH_W-1:0] even_pix, odd_pix;
  logic                     half;

  pfmt_lane_pack #(.CH_W(CH_W), .NCH(NCH)) lane_i (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .two_phase (two_phase),
    .s1_pix    (s1_pix_q),
    .s1_de     (s1_de_q),
    .s1_odd    (s1_odd_q),
    .s1_hs     (s1_hs_q),
    .s1_vs     (s1_vs_q),
    .even_pix  (even_pix),
    .odd_pix   (odd_pix),
    .de_o      (de_out),
    .hs_o      (hs_out),
    .vs_o      (vs_out),
    .half_o    (half)
  );

  assign ev_r        = even_pix[0];
  assign ev_g        = even_pix[1];
  assign ev_b        = even_pix[2];
  assign od_r        = odd_pix[0];
  assign od_g        = odd_pix[1];
  assign od_b        = odd_pix[2];
  assign dclk_full   = clk;
  assign dclk_full_n = ~clk;
  assign dclk_half   = half;
  assign dclk_half_n = ~half;

endmodule

// File: rtl/pfmt_checker.sv
module pfmt_checker #(
  parameter int CH_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            two_phase,
  input logic            depth6,
  input logic            de_in,
  input logic            hs_in,
  input logic            vs_in,
  input logic [CH_W-1:0] ev_r,
  input logic [CH_W-1:0] ev_g,
  input logic [CH_W-1:0] ev_b,
  input logic [CH_W-1:0] od_r,
  input logic [CH_W-1:0] od_g,
  input logic [CH_W-1:0] od_b,
  input logic            de_out,
  input logic            hs_out,
  input logic            vs_out,
  input logic            dclk_half
);

  logic [2:0] up_q;
  logic       settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            up_q <= '0;
    else if (up_q != 3'd7) up_q <= up_q + 3'd1;
  end
  assign settled = (up_q == 3'd7);

  // R5
  p_even_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !two_phase |=> (ev_r == '0 && ev_g == '0 && ev_b == '0));

  // R6
  p_sync_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> (de_out == $past(de_in, 2) && hs_out == $past(hs_in, 2)
                 && vs_out == $past(vs_in, 2)));

  // R8
  p_lsb_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && depth6) |-> (od_r[1:0] == 2'b00 && od_g[1:0] == 2'b00 && od_b[1:0] == 2'b00
                             && ev_r[1:0] == 2'b00 && ev_g[1:0] == 2'b00 && ev_b[1:0] == 2'b00));

  // R10
  p_half_on_update_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && two_phase && $past(two_phase)
     && ({ev_r, ev_g, ev_b} != $past({ev_r, ev_g, ev_b})
         || {od_r, od_g, od_b} != $past({od_r, od_g, od_b}))) |-> dclk_half);

  // R10
  p_half_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && !two_phase && !$past(two_phase)) |-> (dclk_half != $past(dclk_half)));

  // R4
  p_single_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && !two_phase && !$past(two_phase) && !de_out)
      |-> (od_r == '0 && od_g == '0 && od_b == '0));

endmodule

bind pfmt_panel_fmt pfmt_checker #(.CH_W(CH_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .two_phase (two_phase),
  .depth6    (depth6),
  .de_in     (de_in),
  .hs_in     (hs_in),
  .vs_in     (vs_in),
  .ev_r      (ev_r),
  .ev_g      (ev_g),
  .ev_b      (ev_b),
  .od_r      (od_r),
  .od_g      (od_g),
  .od_b      (od_b),
  .de_out    (de_out),
  .hs_out    (hs_out),
  .vs_out    (vs_out),
  .dclk_half (dclk_half)
);

// File: tb/pfmt_panel_fmt_tb_top.sv
module pfmt_panel_fmt_tb_top;

  localparam time CLK_P = 20ns;

  logic clk = 1'b0;
  logic rst_n, two_phase, depth6, de_in, hs_in, vs_in;
  logic [7:0] in_r, in_g, in_b;
  logic [7:0] ev_r, ev_g, ev_b, od_r, od_g, od_b;
  logic de_out, hs_out, vs_out, dclk_full, dclk_full_n, dclk_half, dclk_half_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  pfmt_panel_fmt dut_i (
    .clk(clk), .rst_n(rst_n), .two_phase(two_phase), .depth6(depth6),
    .de_in(de_in), .hs_in(hs_in), .vs_in(vs_in),
    .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .ev_r(ev_r), .ev_g(ev_g), .ev_b(ev_b),
    .od_r(od_r), .od_g(od_g), .od_b(od_b),
    .de_out(de_out), .hs_out(hs_out), .vs_out(vs_out),
    .dclk_full(dclk_full), .dclk_full_n(dclk_full_n),
    .dclk_half(dclk_half), .dclk_half_n(dclk_half_n)
  );

  // {two_phase, depth6, vs_pulse, lines[2:0], npix[7:0], step[7:0], r0, g0, b0}
  localparam int NV = 8;
  localparam logic [45:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 3'd1, 8'd8, 8'd3, 8'd10,   8'd20,   8'd30},
    {1'b1, 1'b0, 1'b0, 3'd2, 8'd5, 8'd7, 8'd1,    8'd100,  8'd200},
    {1'b0, 1'b0, 1'b0, 3'd1, 8'd6, 8'd5, 8'd50,   8'd60,   8'd70},
    {1'b1, 1'b1, 1'b0, 3'd2, 8'd6, 8'd1, 8'h41,   8'h82,   8'hC3},
    {1'b1, 1'b1, 1'b1, 3'd2, 8'd4, 8'd1, 8'h41,   8'h82,   8'hC3},
    {1'b0, 1'b1, 1'b0, 3'd1, 8'd4, 8'd0, 8'hFF,   8'hFE,   8'hFD},
    {1'b1, 1'b0, 1'b0, 3'd1, 8'd1, 8'd0, 8'd9,    8'd8,    8'd7},
    {1'b0, 1'b1, 1'b1, 3'd3, 8'd3, 8'd9, 8'd3,    8'h80,   8'hF1}
  };

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // expected channel value from R7, R8, R9
  function automatic logic [7:0] exp_ch(input logic [7:0] v, input bit d6, input bit x, input bit ph);
    logic [5:0] q;
    logic [1:0] t;
    if (!d6) return v;
    t = ph ? (x ? 2'd1 : 2'd3) : (x ? 2'd2 : 2'd0);
    q = v[7:2];
    if (v[1:0] > t && q != 6'd63) q = q + 6'd1;
    return {q, 2'b00};
  endfunction

  function automatic logic [23:0] exp_px(input logic [23:0] base, input logic [7:0] st,
                                         input int i, input bit d6, input bit ph);
    logic [7:0] off;
    off = 8'(i * st);
    return {exp_ch(base[23:16] + off, d6, i[0], ph),
            exp_ch(base[15:8]  + off, d6, i[0], ph),
            exp_ch(base[7:0]   + off, d6, i[0], ph)};
  endfunction

  function automatic logic [47:0] ports();
    return {ev_r, ev_g, ev_b, od_r, od_g, od_b};
  endfunction

  task automatic idle_in();
    de_in = 0; hs_in = 0; vs_in = 0; in_r = 0; in_g = 0; in_b = 0;
  endtask

  task automatic do_reset(input bit tp, input bit d6);
    @(negedge clk);
    rst_n = 0;
    two_phase = tp; depth6 = d6;
    idle_in();
    @(negedge clk);
    // R11: outputs cleared while reset is held
    chk("R11", {ports(), 1'b0, de_out, hs_out, vs_out}, '0);
    chk("R11", {46'd0, dclk_half, dclk_half_n}, {46'd0, 1'b0, 1'b1});
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_line(input bit tp, input bit d6, input int npix,
                          input logic [23:0] base, input logic [7:0] st, input bit ph);
    logic [23:0] pv;
    bit          prev_half;
    string       tag;
    prev_half = dclk_half;
    for (int c = 0; c <= npix + 3; c++) begin
      @(negedge clk);
      if (c >= 2) chk("R6 de", {47'd0, de_out}, {47'd0, ((c - 2) < npix)});
      if (c == npix + 3) chk("R6 hs", {47'd0, hs_out}, 48'd1);
      if (tp) begin
        if (c >= 3 && (c - 3) % 2 == 0 && (c - 3) < npix) begin
          int i = c - 3;
          tag = (i + 1 < npix) ? "R1" : "R3";
          tag = {tag, d6 ? " R8 R9" : " R7"};
          chk(tag, ports(), {exp_px(base, st, i, d6, ph),
                             (i + 1 < npix) ? exp_px(base, st, i + 1, d6, ph) : 24'd0});
          chk("R10 half on update", {47'd0, dclk_half}, 48'd1);
        end
        if (c >= 4 && (c - 4) % 2 == 0 && (c - 4) < npix) begin
          int i = c - 4;
          chk("R1 hold", ports(), {exp_px(base, st, i, d6, ph),
                                   (i + 1 < npix) ? exp_px(base, st, i + 1, d6, ph) : 24'd0});
        end
      end else begin
        if (c >= 2 && (c - 2) < npix) begin
          tag = d6 ? "R4 R5 R8 R9" : "R4 R5 R7";
          chk(tag, ports(), {24'd0, exp_px(base, st, c - 2, d6, ph)});
        end
        if (c >= 1) chk("R10 toggle", {47'd0, dclk_half}, {47'd0, ~prev_half});
        prev_half = dclk_half;
      end
      if (c < npix) begin
        pv = {base[23:16] + 8'(c * st), base[15:8] + 8'(c * st), base[7:0] + 8'(c * st)};
        de_in = 1; in_r = pv[23:16]; in_g = pv[15:8]; in_b = pv[7:0];
      end else begin
        de_in = 0; in_r = 0; in_g = 0; in_b = 0;
      end
      hs_in = (c == npix + 1);
    end
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; two_phase = 0; depth6 = 0;
    idle_in();

    for (int v = 0; v < NV; v++) begin
      bit tp, d6, vsp, row, frm;
      int nl, np;
      tp  = VEC[v][45];
      d6  = VEC[v][44];
      vsp = VEC[v][43];
      nl  = int'(VEC[v][42:40]);
      np  = int'(VEC[v][39:32]);
      do_reset(tp, d6);
      row = 0; frm = 0;
      if (vsp) begin
        vs_in = 1;
        @(negedge clk);
        vs_in = 0;
        @(negedge clk);
        chk("R6 vs", {47'd0, vs_out}, 48'd1); // R9 frame flip follows
        frm = ~frm; row = 0;
        @(negedge clk);
      end
      for (int l = 0; l < nl; l++) begin
        run_line(tp, d6, np, VEC[v][23:0], VEC[v][31:24], row ^ frm);
        row = ~row;
      end
    end

    // full-rate clock pair sampled at the falling edge
    chk("R10 full clk", {46'd0, dclk_full, dclk_full_n}, {46'd0, 1'b0, 1'b1});

    // R2 and R3: one idle cycle between a 3-pixel line and a 2-pixel line
    do_reset(1, 0);
    for (int c = 0; c <= 9; c++) begin
      @(negedge clk);
      if (c == 3) chk("R1 gap pair", ports(), {24'h102030, 24'h112131});
      if (c == 5) chk("R3 gap fill", ports(), {24'h122232, 24'h000000});
      if (c == 6) chk("R3 gap hold", ports(), {24'h122232, 24'h000000});
      if (c == 7) chk("R2 restart", ports(), {24'h90A0B0, 24'h91A1B1});
      if (c <= 2) begin
        de_in = 1; in_r = 8'(16 + c); in_g = 8'(32 + c); in_b = 8'(48 + c);
      end else if (c == 4 || c == 5) begin
        de_in = 1; in_r = 8'(8'h90 + c - 4); in_g = 8'(8'hA0 + c - 4); in_b = 8'(8'hB0 + c - 4);
      end else begin
        de_in = 0; in_r = 0; in_g = 0; in_b = 0;
      end
    end

    // R11: reset asserted in the middle of a line clears ports at once
    do_reset(1, 0);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      de_in = 1; in_r = 8'h55; in_g = 8'h66; in_b = 8'h77;
    end
    @(negedge clk);
    chk("R1 pre-reset", ports(), {24'h556677, 24'h556677});
    rst_n = 0;
    #1;
    chk("R11 mid-line", {ports(), 1'b0, de_out, hs_out, vs_out}, '0);
    idle_in();
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule